// File: doc/BRIEF.md
# Two-Level Interrupt Aggregation Controller

This block gathers single-cycle event pulses from four groups: two identical physical-port groups of seven events each, a twelve-line general-purpose I/O group, and a five-event host MAC group. It drives one active-high interrupt line. The two port groups and the I/O group each keep a sticky leaf status register and a leaf enable register. Each group's enabled pending events are folded into one fixed summary bit of a top-level status register. The host MAC events have no leaf register and are held directly in the top-level status register.

The top-level status is masked by a top-level enable register. A global interrupt enable in a configuration register then gates the result, which is registered onto the output pin. Software reaches every register through a plain write strobe, an address and a combinational read-data bus. Every status bit is cleared by writing 1 to it. A leaf status bit records its event even while the event is disabled, so enabling that event later raises the interrupt without a new event.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every status register, every enable register and the configuration register read 0, and `irq_o` is low.
- R2: An event pulse sets its leaf status bit, whether or not the event is enabled, and the bit stays set after the pulse ends. Port 1 status is at address 3, port 1 enable at 4, port 2 status at 5, port 2 enable at 6. Event k maps to bit k.
- R3: Writing 1 to a leaf status bit clears it. Writing 0 leaves it unchanged.
- R4: When an event pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R5: Top-level status (address 0) bit 26 is the OR of the port 1 leaf status ANDed with its enable. Bit 27 is the same for port 2, and bit 12 is the same for the I/O group. These bits follow the leaf state: clearing the leaf bits clears them, and writes to them have no effect.
- R6: Host MAC events 0..4 set sticky top-level status bits 0..4. Writing 1 to those bits at address 0 clears them.
- R7: `irq_o` is high exactly one cycle after a cycle in which (top status AND top enable at address 1) is nonzero and configuration (address 2) bit 8 is set. Otherwise it is low one cycle later.
- R8: Enabling an already pending leaf event raises `irq_o` one cycle after the enable write takes effect, with no new event.
- R9: The I/O register (address 7) holds status at bits 11:0 and enable at bits 27:16. A write clears the status bits that are written as 1 and loads the whole enable field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy1_evt_i | input | 7 | Port 1 event pulses |
| phy2_evt_i | input | 7 | Port 2 event pulses |
| gpio_evt_i | input | 12 | I/O line event pulses |
| mac_evt_i | input | 5 | Host MAC event pulses |
| reg_wen_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| irq_o | output | 1 | Registered interrupt output |

## Verification
An incoming event pulse and a software write-one-to-clear can land on the same status bit in the same cycle. The bench provokes this by raising a port event and writing a clear mask with that bit set in one clock. It then reads the register back and expects the bit to be set. A second collision is between an enable write and an existing pending bit. Here the bench judges timing: `irq_o` must stay low in the cycle right after the write and be high in the cycle after that.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int DW          = 32;
  localparam int AW          = 3;
  localparam int PHY_EVTS    = 7;
  localparam int GPIO_LINES  = 12;
  localparam int MAC_EVTS    = 5;
  localparam int NUM_PORTS   = 2;

  // fixed bit positions
  localparam int TOP_PHY1_BIT = 26;
  localparam int TOP_PHY2_BIT = 27;
  localparam int TOP_GPIO_BIT = 12;
  localparam int TOP_MAC_LSB  = 0;
  localparam int CFG_GIE_BIT  = 8;
  localparam int GPIO_EN_LSB  = 16;

  // register addresses
  localparam logic [AW-1:0] A_TOP_STAT  = 3'd0;
  localparam logic [AW-1:0] A_TOP_EN    = 3'd1;
  localparam logic [AW-1:0] A_CFG       = 3'd2;
  localparam logic [AW-1:0] A_PHY1_STAT = 3'd3;
  localparam logic [AW-1:0] A_PHY1_EN   = 3'd4;
  localparam logic [AW-1:0] A_PHY2_STAT = 3'd5;
  localparam logic [AW-1:0] A_PHY2_EN   = 3'd6;
  localparam logic [AW-1:0] A_GPIO      = 3'd7;

  // sticky update: clear by mask, then set by event (set wins)
  function automatic logic [DW-1:0] sticky_next(input logic [DW-1:0] cur,
                                                 input logic [DW-1:0] clr,
                                                 input logic [DW-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic any_enabled(input logic [DW-1:0] stat,
                                       input logic [DW-1:0] en);
    return (stat & en) != '0;
  endfunction
endpackage

// File: rtl/irq_leaf_group.sv
module irq_leaf_group
  import irq_agg_pkg::*;
#(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] clr_i,
  input  logic         en_we_i,
  input  logic [W-1:0] en_wdata_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] enable_o,
  output logic         summary_o
);
  localparam int PAD = DW - W;

  logic [W-1:0]  status_q;
  logic [W-1:0]  enable_q;
  logic [DW-1:0] status_wide_nxt;

  always_comb begin
    status_wide_nxt = sticky_next({{PAD{1'b0}}, status_q},
                                  {{PAD{1'b0}}, clr_i},
                                  {{PAD{1'b0}}, evt_i});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
    end else begin
      status_q <= status_wide_nxt[W-1:0];
      if (en_we_i) enable_q <= en_wdata_i;
    end
  end

  assign status_o  = status_q;
  assign enable_o  = enable_q;
  assign summary_o = any_enabled({{PAD{1'b0}}, status_q}, {{PAD{1'b0}}, enable_q});

  AST_EVT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((status_q & $past(evt_i)) == $past(evt_i))); // R4
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~evt_i) != '0) |=> ((status_q & $past(clr_i & ~evt_i)) == '0)); // R3
  AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i == '0 && clr_i == '0) |=> $stable(status_q)); // R2
endmodule

// File: rtl/irq_top_block.sv
module irq_top_block
  import irq_agg_pkg::*;
#(
  parameter int MAC_N = MAC_EVTS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [MAC_N-1:0] mac_evt_i,
  input  logic [MAC_N-1:0] mac_clr_i,
  input  logic          phy1_sum_i,
  input  logic          phy2_sum_i,
  input  logic          gpio_sum_i,
  input  logic          en_we_i,
  input  logic          cfg_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] status_o,
  output logic [DW-1:0] enable_o,
  output logic [DW-1:0] cfg_o,
  output logic          pending_o
);
  localparam int PAD = DW - MAC_N;

  logic [MAC_N-1:0] mac_q;
  logic [DW-1:0]    mac_wide_nxt;
  logic [DW-1:0]    enable_q;
  logic [DW-1:0]    cfg_q;
  logic [DW-1:0]    status_w;

  always_comb begin
    mac_wide_nxt = sticky_next({{PAD{1'b0}}, mac_q},
                               {{PAD{1'b0}}, mac_clr_i},
                               {{PAD{1'b0}}, mac_evt_i});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mac_q    <= '0;
      enable_q <= '0;
      cfg_q    <= '0;
    end else begin
      mac_q <= mac_wide_nxt[MAC_N-1:0];
      if (en_we_i)  enable_q <= wdata_i;
      if (cfg_we_i) cfg_q    <= wdata_i;
    end
  end

  always_comb begin
    status_w = '0;
    status_w[TOP_MAC_LSB +: MAC_N] = mac_q;
    status_w[TOP_GPIO_BIT]         = gpio_sum_i;
    status_w[TOP_PHY1_BIT]         = phy1_sum_i;
    status_w[TOP_PHY2_BIT]         = phy2_sum_i;
  end

  assign status_o  = status_w;
  assign enable_o  = enable_q;
  assign cfg_o     = cfg_q;
  assign pending_o = any_enabled(status_w, enable_q) && cfg_q[CFG_GIE_BIT];

  AST_MAC_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_evt_i != '0) |=> ((mac_q & $past(mac_evt_i)) == $past(mac_evt_i))); // R6
  AST_MAC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ((mac_clr_i & ~mac_evt_i) != '0) |=> ((mac_q & $past(mac_clr_i & ~mac_evt_i)) == '0)); // R6
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic pending_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= pending_i;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int PHY_N  = PHY_EVTS,
  parameter int GPIO_N = GPIO_LINES,
  parameter int MAC_N  = MAC_EVTS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PHY_N-1:0]  phy1_evt_i,
  input  logic [PHY_N-1:0]  phy2_evt_i,
  input  logic [GPIO_N-1:0] gpio_evt_i,
  input  logic [MAC_N-1:0]  mac_evt_i,
  input  logic              reg_wen_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              irq_o
);
  // named write hits
  logic wr_top_stat, wr_top_en, wr_cfg, wr_gpio;
  logic [NUM_PORTS-1:0] wr_phy_stat, wr_phy_en;

  assign wr_top_stat    = reg_wen_i && (reg_addr_i == A_TOP_STAT);
  assign wr_top_en      = reg_wen_i && (reg_addr_i == A_TOP_EN);
  assign wr_cfg         = reg_wen_i && (reg_addr_i == A_CFG);
  assign wr_gpio        = reg_wen_i && (reg_addr_i == A_GPIO);
  assign wr_phy_stat[0] = reg_wen_i && (reg_addr_i == A_PHY1_STAT);
  assign wr_phy_en[0]   = reg_wen_i && (reg_addr_i == A_PHY1_EN);
  assign wr_phy_stat[1] = reg_wen_i && (reg_addr_i == A_PHY2_STAT);
  assign wr_phy_en[1]   = reg_wen_i && (reg_addr_i == A_PHY2_EN);

  // port groups
  logic [NUM_PORTS-1:0][PHY_N-1:0] phy_evt, phy_stat, phy_en;
  logic [NUM_PORTS-1:0]            phy_sum;

  assign phy_evt[0] = phy1_evt_i;
  assign phy_evt[1] = phy2_evt_i;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    irq_leaf_group #(.W(PHY_N)) u_leaf (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_i      (phy_evt[p]),
      .clr_i      (wr_phy_stat[p] ? reg_wdata_i[PHY_N-1:0] : '0),
      .en_we_i    (wr_phy_en[p]),
      .en_wdata_i (reg_wdata_i[PHY_N-1:0]),
      .status_o   (phy_stat[p]),
      .enable_o   (phy_en[p]),
      .summary_o  (phy_sum[p])
    );
  end

  // I/O group
  logic [GPIO_N-1:0] gpio_stat, gpio_en;
  logic              gpio_sum;

  irq_leaf_group #(.W(GPIO_N)) u_gpio (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (gpio_evt_i),
    .clr_i      (wr_gpio ? reg_wdata_i[GPIO_N-1:0] : '0),
    .en_we_i    (wr_gpio),
    .en_wdata_i (reg_wdata_i[GPIO_EN_LSB +: GPIO_N]),
    .status_o   (gpio_stat),
    .enable_o   (gpio_en),
    .summary_o  (gpio_sum)
  );

  // top level
  logic [DW-1:0] top_stat, top_en, cfg;
  logic          pending;

  irq_top_block #(.MAC_N(MAC_N)) u_top (
    .clk        (clk),
    .rst_n      (rst_n),
    .mac_evt_i  (mac_evt_i),
    .mac_clr_i  (wr_top_stat ? reg_wdata_i[TOP_MAC_LSB +: MAC_N] : '0),
    .phy1_sum_i (phy_sum[0]),
    .phy2_sum_i (phy_sum[1]),
    .gpio_sum_i (gpio_sum),
    .en_we_i    (wr_top_en),
    .cfg_we_i   (wr_cfg),
    .wdata_i    (reg_wdata_i),
    .status_o   (top_stat),
    .enable_o   (top_en),
    .cfg_o      (cfg),
    .pending_o  (pending)
  );

  irq_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .pending_i (pending),
    .irq_o     (irq_o)
  );

  // read mux
  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      A_TOP_STAT:  reg_rdata_o = top_stat;
      A_TOP_EN:    reg_rdata_o = top_en;
      A_CFG:       reg_rdata_o = cfg;
      A_PHY1_STAT: reg_rdata_o[PHY_N-1:0] = phy_stat[0];
      A_PHY1_EN:   reg_rdata_o[PHY_N-1:0] = phy_en[0];
      A_PHY2_STAT: reg_rdata_o[PHY_N-1:0] = phy_stat[1];
      A_PHY2_EN:   reg_rdata_o[PHY_N-1:0] = phy_en[1];
      A_GPIO: begin
        reg_rdata_o[GPIO_N-1:0]              = gpio_stat;
        reg_rdata_o[GPIO_EN_LSB +: GPIO_N]   = gpio_en;
      end
      default:     reg_rdata_o = '0;
    endcase
  end

  AST_IRQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == ($past((top_stat & top_en) != '0) && $past(cfg[CFG_GIE_BIT])))); // R7
  AST_PHY1_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    ((phy_stat[0] & phy_en[0]) == '0) |-> !top_stat[TOP_PHY1_BIT]); // R5
  AST_PHY2_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    ((phy_stat[1] & phy_en[1]) != '0) |-> top_stat[TOP_PHY2_BIT]); // R5
  AST_GPIO_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    ((gpio_stat & gpio_en) == '0) |-> !top_stat[TOP_GPIO_BIT]); // R5
endmodule

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  phy1_evt = '0, phy2_evt = '0;
  logic [11:0] gpio_evt = '0;
  logic [4:0]  mac_evt = '0;
  logic        wen = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  irq_aggregator u_dut (
    .clk(clk), .rst_n(rst_n),
    .phy1_evt_i(phy1_evt), .phy2_evt_i(phy2_evt),
    .gpio_evt_i(gpio_evt), .mac_evt_i(mac_evt),
    .reg_wen_i(wen), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wen = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wen = 1'b0; wdata = '0;
  endtask

  task automatic rd_check(input string req, input logic [2:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  task automatic pulse(input logic [6:0] p1, input logic [6:0] p2,
                       input logic [11:0] g, input logic [4:0] m);
    @(negedge clk);
    phy1_evt = p1; phy2_evt = p2; gpio_evt = g; mac_evt = m;
    @(posedge clk);
    @(negedge clk);
    phy1_evt = '0; phy2_evt = '0; gpio_evt = '0; mac_evt = '0;
  endtask

  task automatic t_reset;
    for (int a = 0; a < 8; a++) rd_check("R1 reset value", 3'(a), 32'h0);
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_sticky;
    pulse(7'h08, 7'h00, 12'h0, 5'h0);
    repeat (2) @(negedge clk);
    rd_check("R2 port1 event held while disabled", 3'd3, 32'h08);
    check("R2 no irq when disabled", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_w1c;
    wr(3'd3, 32'h0000_0000);
    rd_check("R3 write 0 keeps bit", 3'd3, 32'h08);
    wr(3'd3, 32'h0000_0008);
    rd_check("R3 write 1 clears bit", 3'd3, 32'h00);
  endtask

  task automatic t_set_wins;
    pulse(7'h00, 7'h02, 12'h0, 5'h0);
    rd_check("R2 port2 event held", 3'd5, 32'h02);
    @(negedge clk);
    phy2_evt = 7'h02; wen = 1'b1; addr = 3'd5; wdata = 32'h02;
    @(posedge clk);
    @(negedge clk);
    phy2_evt = '0; wen = 1'b0; wdata = '0;
    rd_check("R4 set wins over clear", 3'd5, 32'h02);
  endtask

  task automatic t_summary;
    rd_check("R5 summary off while disabled", 3'd0, 32'h0);
    wr(3'd6, 32'h02);
    rd_check("R5 port2 summary bit 27", 3'd0, 32'h0800_0000);
    wr(3'd0, 32'h0800_0000);
    rd_check("R5 summary ignores writes", 3'd0, 32'h0800_0000);
    wr(3'd5, 32'h02);
    rd_check("R5 summary clears with leaf", 3'd0, 32'h0);
    wr(3'd6, 32'h00);
  endtask

  task automatic t_mac;
    pulse(7'h00, 7'h00, 12'h0, 5'h04);
    rd_check("R6 mac event 2 at bit 2", 3'd0, 32'h04);
    wr(3'd0, 32'h01);
    rd_check("R6 clearing other bit keeps it", 3'd0, 32'h04);
    wr(3'd0, 32'h04);
    rd_check("R6 mac w1c", 3'd0, 32'h0);
  endtask

  task automatic t_gating;
    pulse(7'h00, 7'h00, 12'h020, 5'h0);
    wr(3'd7, 32'h0020_0000);
    rd_check("R9 gpio layout", 3'd7, 32'h0020_0020);
    rd_check("R5 gpio summary bit 12", 3'd0, 32'h0000_1000);
    wr(3'd1, 32'h0000_1000);
    @(negedge clk);
    check("R7 no irq without global enable", {31'b0, irq}, 32'h0);
    wr(3'd2, 32'h0000_0100);
    check("R7 irq not yet high", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R7 irq one cycle later", {31'b0, irq}, 32'h1);
    wr(3'd1, 32'h0);
    check("R7 irq still high", {31'b0, irq}, 32'h1);
    @(negedge clk);
    check("R7 irq drops after top disable", {31'b0, irq}, 32'h0);
    wr(3'd7, 32'h0000_0020);
    rd_check("R9 gpio clear and enable load", 3'd7, 32'h0);
  endtask

  task automatic t_late_enable;
    pulse(7'h01, 7'h00, 12'h0, 5'h0);
    wr(3'd1, 32'h0400_0000);
    @(negedge clk);
    check("R8 no irq before leaf enable", {31'b0, irq}, 32'h0);
    wr(3'd4, 32'h01);
    check("R8 irq not yet", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R8 pending raises irq", {31'b0, irq}, 32'h1);
    wr(3'd3, 32'h01);
    @(negedge clk);
    check("R3 irq drops after leaf clear", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    #(8 * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sticky();
    t_w1c();
    t_set_wins();
    t_summary();
    t_mac();
    t_gating();
    t_late_enable();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule